// File: doc/BRIEF.md
# Cascadable Lookahead Carry and Status Generator

This block is the carry and status side of one 16-bit slice of a wide adder/logic unit. From the two operands, a 3-bit function code and a carry input, it forms per-bit generate and propagate terms and builds the group lookahead terms from them. It drives four outputs: group generate and group propagate, both active low, for an external lookahead unit that ties several slices together, plus the slice carry out and a two's-complement overflow flag. The sum itself is formed elsewhere.

Three of the eight function codes are arithmetic: plain addition, addition with the first operand inverted, and addition with the second operand inverted. For the two inverted forms the block complements the chosen operand before it builds any term. For the other codes (clear, the three bitwise logic operations and preset) the slice takes no part in carry propagation, and its outputs sit in a fixed idle state.

The logic is purely combinational. Every output follows its inputs in the same cycle.

Top module: `lookahead_status_gen`

## Requirements
- R1: The function code `fsel` is decoded as follows: 3'b011 is A+B, 3'b001 is NOT(A)+B, 3'b010 is A+NOT(B). All other codes are non-arithmetic: 3'b000 clear, 3'b100 xor, 3'b101 or, 3'b110 and, 3'b111 preset.
- R2: For A+B, `cout` equals bit 16 of the 17-bit sum A+B+`cin`.
- R3: For NOT(A)+B, `cout` equals bit 16 of (~A)+B+`cin`.
- R4: For A+NOT(B), `cout` equals bit 16 of A+(~B)+`cin`.
- R5: For an arithmetic code, `ovf` is the carry into bit 15 XOR the carry out of bit 15. Both carries are taken from the same effective sum as `cout`.
- R6: For an arithmetic code, `gen_n` is low exactly when the effective operands produce a carry out of bit 15 with a carry input of 0.
- R7: For an arithmetic code, `prop_n` is low exactly when every bit position of the effective operands has at least one operand bit set.
- R8: For any non-arithmetic code, `gen_n` and `prop_n` are high and `cout` and `ovf` are low, whatever the operands and `cin`.
- R9: `cin` has no effect on `gen_n` or `prop_n`.
- R10: All outputs are combinational and are valid in the same cycle as the inputs, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| fsel | input | 3 | Function code |
| cin | input | 1 | Carry into bit 0 |
| gen_n | output | 1 | Group generate, active low |
| prop_n | output | 1 | Group propagate, active low |
| cout | output | 1 | Carry out of bit 15 |
| ovf | output | 1 | Two's-complement overflow |

## Verification
No result depends on a clock edge. Each of the four outputs is due in the same cycle that its stimulus is applied. The bench drives operands, function code and carry input on the falling clock edge and samples all outputs one nanosecond after the next rising edge, by which time the inputs have settled for half a period. For the carry independence check, only `cin` changes between two samples, so any movement of `gen_n` or `prop_n` is caught in that one cycle.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;
  typedef enum logic [2:0] {
    FN_CLEAR  = 3'b000,
    FN_NAPLB  = 3'b001,
    FN_APLNB  = 3'b010,
    FN_ADD    = 3'b011,
    FN_XOR    = 3'b100,
    FN_OR     = 3'b101,
    FN_AND    = 3'b110,
    FN_PRESET = 3'b111
  } fn_e;
endpackage

// File: rtl/la_operand_cond.sv
module la_operand_cond
  import lookahead_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  fn_e              fn,
  output logic [WIDTH-1:0] eff_a,
  output logic [WIDTH-1:0] eff_b,
  output logic             arith
);
  // R1: pick the operand to invert from the function code
  always_comb begin
    eff_a = opa;
    eff_b = opb;
    arith = 1'b0;
    unique case (fn)
      FN_ADD:   arith = 1'b1;
      FN_NAPLB: begin arith = 1'b1; eff_a = ~opa; end
      FN_APLNB: begin arith = 1'b1; eff_b = ~opb; end
      default:  arith = 1'b0;
    endcase
  end
endmodule

// File: rtl/la_bit_pg.sv
module la_bit_pg #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] eff_a,
  input  logic [WIDTH-1:0] eff_b,
  output logic [WIDTH-1:0] bit_p,
  output logic [WIDTH-1:0] bit_g
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_p[i] = eff_a[i] | eff_b[i];
    assign bit_g[i] = eff_a[i] & eff_b[i];
  end
endmodule

// File: rtl/la_prefix_chain.sv
module la_prefix_chain #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] bit_p,
  input  logic [WIDTH-1:0] bit_g,
  input  logic             cin,
  output logic             grp_g,
  output logic             grp_p,
  output logic             c_msb,
  output logic             c_out
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] run_g;
  logic [WIDTH-1:0] run_p;

  always_comb begin
    run_g[0] = bit_g[0];
    run_p[0] = bit_p[0];
    for (int i = 1; i < WIDTH; i++) begin
      run_g[i] = bit_g[i] | (bit_p[i] & run_g[i-1]);
      run_p[i] = bit_p[i] & run_p[i-1];
    end
  end

  assign grp_g = run_g[TOP];
  assign grp_p = run_p[TOP];
  assign c_msb = run_g[TOP-1] | (run_p[TOP-1] & cin);
  assign c_out = run_g[TOP] | (run_p[TOP] & cin);

  // R6: a generated carry leaves the group regardless of cin
  always_comb begin
    assert_gen_forces_carry_R6: assert (!grp_g || c_out)
      else $error("group generate without carry out");
    // R7: full propagate passes an incoming carry
    assert_prop_passes_carry_R7: assert (!(grp_p && cin) || c_out)
      else $error("propagated carry lost");
    // R2: no generate and no full propagate means no carry
    assert_no_spurious_carry_R2: assert (grp_g || grp_p || !c_out)
      else $error("carry out without source");
  end
endmodule

// File: rtl/lookahead_status_gen.sv
module lookahead_status_gen
  import lookahead_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       fsel,
  input  logic             cin,
  output logic             gen_n,
  output logic             prop_n,
  output logic             cout,
  output logic             ovf
);
  logic [WIDTH-1:0] eff_a, eff_b, bit_p, bit_g;
  logic             arith, grp_g, grp_p, c_msb, c_out;

  la_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .opa(opa), .opb(opb), .fn(fn_e'(fsel)),
    .eff_a(eff_a), .eff_b(eff_b), .arith(arith)
  );

  la_bit_pg #(.WIDTH(WIDTH)) u_pg (
    .eff_a(eff_a), .eff_b(eff_b), .bit_p(bit_p), .bit_g(bit_g)
  );

  la_prefix_chain #(.WIDTH(WIDTH)) u_chain (
    .bit_p(bit_p), .bit_g(bit_g), .cin(cin),
    .grp_g(grp_g), .grp_p(grp_p), .c_msb(c_msb), .c_out(c_out)
  );

  // R8: idle outputs for non-arithmetic codes; R5 overflow from top carries
  always_comb begin
    gen_n  = 1'b1;
    prop_n = 1'b1;
    cout   = 1'b0;
    ovf    = 1'b0;
    if (arith) begin
      gen_n  = ~grp_g;
      prop_n = ~grp_p;
      cout   = c_out;
      ovf    = c_msb ^ c_out;
    end
  end

  always_comb begin
    assert_idle_outputs_R8: assert (arith || (gen_n && prop_n && !cout && !ovf))
      else $error("non-arithmetic code drove status");
    assert_arith_codes_R1: assert (arith == (fsel inside {3'b001, 3'b010, 3'b011}))
      else $error("arithmetic decode mismatch");
  end
endmodule

// File: tb/sim_lookahead_status_gen.sv
module sim_lookahead_status_gen;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] opa, opb;
  logic [2:0] fsel;
  logic cin;
  logic gen_n, prop_n, cout, ovf;
  int checks = 0;
  int errors = 0;

  always #5ns clk = ~clk;

  lookahead_status_gen #(.WIDTH(W)) u0 (
    .opa(opa), .opb(opb), .fsel(fsel), .cin(cin),
    .gen_n(gen_n), .prop_n(prop_n), .cout(cout), .ovf(ovf)
  );

  // {fsel, opa, opb, cin, cout, ovf, gen_n, prop_n}
  localparam logic [39:0] VEC [12] = '{
    {3'b011, 16'hFFFF, 16'h0001, 1'b1 ^ 1'b1, 4'b1000},
    {3'b011, 16'h7FFF, 16'h0001, 1'b0, 4'b0111},
    {3'b011, 16'h8000, 16'h8000, 1'b0, 4'b1101},
    {3'b011, 16'h0000, 16'h0000, 1'b1, 4'b0011},
    {3'b011, 16'hFFFF, 16'h0000, 1'b1, 4'b1010},
    {3'b001, 16'h0001, 16'h0001, 1'b1, 4'b1010},
    {3'b010, 16'h0000, 16'h0001, 1'b1, 4'b0011},
    {3'b010, 16'h8000, 16'h0001, 1'b1, 4'b1101},
    {3'b000, 16'hFFFF, 16'hFFFF, 1'b1, 4'b0011},
    {3'b111, 16'hFFFF, 16'hFFFF, 1'b1, 4'b0011},
    {3'b100, 16'h1234, 16'h5678, 1'b1, 4'b0011},
    {3'b001, 16'hFFFF, 16'hFFFF, 1'b0, 4'b0010}
  };

  function automatic logic [3:0] ref_model(input logic [2:0] f, input logic [W-1:0] a,
                                           input logic [W-1:0] b, input logic c);
    logic [W-1:0] ea, eb;
    logic [W:0] s, s0;
    logic [W-1:0] lo;
    logic c15;
    if (!(f inside {3'b001, 3'b010, 3'b011})) return 4'b0011;
    ea = (f == 3'b001) ? ~a : a;
    eb = (f == 3'b010) ? ~b : b;
    s  = {1'b0, ea} + {1'b0, eb} + {{W{1'b0}}, c};
    s0 = {1'b0, ea} + {1'b0, eb};
    lo = {1'b0, ea[W-2:0]} + {1'b0, eb[W-2:0]} + {{(W-1){1'b0}}, c};
    c15 = lo[W-1];
    return {s[W], c15 ^ s[W], ~s0[W], ~(&(ea | eb))};
  endfunction

  task automatic apply(input logic [2:0] f, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic c);
    @(negedge clk);
    fsel = f; opa = a; opb = b; cin = c;
    @(posedge clk);
    #1ns;
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if ({cout, ovf, gen_n, prop_n} !== exp) begin
      errors++;
      $display("FAIL %s fsel=%b a=%h b=%h cin=%b actual {cout,ovf,gen_n,prop_n}=%b expected=%b",
               req, fsel, opa, opb, cin, {cout, ovf, gen_n, prop_n}, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'b011:  return "R2/R5/R6/R7";
      3'b001:  return "R3/R5/R6/R7";
      3'b010:  return "R4/R5/R6/R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #2000000ns;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fsel = 3'b000; opa = '0; opb = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1ns;
    check("R8 reset idle", 4'b0011);

    // table-driven vectors (R1 decode of each code)
    foreach (VEC[i]) begin
      apply(VEC[i][39:37], VEC[i][36:21], VEC[i][20:5], VEC[i][4]);
      check({"R1 ", req_of(VEC[i][39:37])}, VEC[i][3:0]);
    end

    // R10: same-cycle response, change and sample within one half period
    @(negedge clk);
    fsel = 3'b011; opa = 16'h00FF; opb = 16'h0F01; cin = 1'b1;
    #1ns;
    check("R10", ref_model(fsel, opa, opb, cin));

    // R9: cin must not move gen_n or prop_n
    for (int k = 0; k < 3; k++) begin
      logic [2:0] f;
      logic g0, p0;
      f = (k == 0) ? 3'b011 : (k == 1) ? 3'b001 : 3'b010;
      apply(f, 16'h5A5A, 16'hA5A5, 1'b0);
      g0 = gen_n; p0 = prop_n;
      apply(f, 16'h5A5A, 16'hA5A5, 1'b1);
      checks++;
      if (gen_n !== g0 || prop_n !== p0) begin
        errors++;
        $display("FAIL R9 actual gen_n/prop_n=%b%b expected=%b%b", gen_n, prop_n, g0, p0);
      end
    end

    // R8: every non-arithmetic code with all-ones operands and cin high
    for (int f = 0; f < 8; f++) begin
      if (!(f inside {1, 2, 3})) begin
        apply(3'(f), 16'hFFFF, 16'hFFFF, 1'b1);
        check("R8", 4'b0011);
      end
    end

    // random operands, both cin values, all codes
    for (int n = 0; n < 600; n++) begin
      logic [2:0] f;
      logic [W-1:0] a, b;
      logic c;
      f = 3'($urandom_range(0, 7));
      a = 16'($urandom);
      b = (n % 5 == 0) ? ~a : 16'($urandom);
      c = n[0];
      apply(f, a, b, c);
      check(req_of(f), ref_model(f, a, b, c));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule